// File: doc/BRIEF.md
# DMA Parity Error Response Controller

This block decides what a bus-master network controller does after a data parity error shows up on one of its own DMA transfers. Every such error raises a sticky system-error flag, which can drive an interrupt request. The host clears the flag by writing a one to it.

When the advanced response is enabled, and the descriptor format is one of the two 32-bit styles, the block reacts according to the kind of transfer that failed:
- An initialization-block read stops the controller.
- A descriptor read or write first brings an active transmission to an orderly end, and then stops the controller.
- A transmit buffer read marks the current transmit descriptor and aborts the transmission.
- A receive buffer write marks the last descriptor of the frame.

In basic mode the error is reported through the flag and nothing else changes. The transmitter's abort mechanics and the bus interface are not part of this block.

Top module: `dma_perr_ctrl`

## Requirements
- R1: A cycle with `perr_i` high sets `sint_flag_o` to 1 at the next clock edge. The flag stays 1 until it is cleared or reset.
- R2: `irq_o` is 1 exactly when `sint_flag_o` and `sint_ie_i` are both 1.
- R3: `sint_clr_i` high clears the flag at the next edge. If `perr_i` is high in the same cycle, the flag stays 1.
- R4: The advanced response is active only when `adv_en_i` is 1 and `desc_style_i` is 2 or 3. In any other case an error drives no stop, no abort and no descriptor mark.
- R5: With the advanced response active, an error of kind 0 (initialization read) gives a one-cycle `stop_req_o` pulse right after the error cycle.
- R6: With the advanced response active, an error of kind 1 (descriptor read) or kind 2 (descriptor write) behaves as follows:
  - If `tx_busy_i` is 0, it gives the stop pulse right after the error cycle.
  - Otherwise `tx_abort_req_o` is held high from the next cycle on. The stop pulse follows the first cycle in which `tx_busy_i` is sampled 0, and the abort request drops with it.
- R7: With the advanced response active, an error of kind 3 (transmit buffer read) gives, in the next cycle, a one-cycle `tx_abort_req_o` pulse together with `tx_desc_set_o` equal to a mask with only bit 23 set.
- R8: With the advanced response active, an error of kind 4 (receive buffer write) is remembered. `rx_desc_set_o` shows the bit-23 mask in the same cycle as the next `rx_last_wr_i` pulse, and that pulse clears the memory.
- R9: While a stop sequence is under way, further stop-causing errors neither restart nor extend it. Kinds 5 to 7 only set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perr_i | input | 1 | Data parity error seen on own DMA transfer |
| perr_kind_i | input | 3 | Transfer kind: 0 init read, 1 desc read, 2 desc write, 3 tx buffer read, 4 rx buffer write |
| sint_ie_i | input | 1 | Interrupt enable for the system-error flag |
| adv_en_i | input | 1 | Advanced parity response enable |
| desc_style_i | input | 8 | Descriptor format setting |
| sint_clr_i | input | 1 | Host write-one-to-clear of the flag |
| tx_busy_i | input | 1 | Transmitter currently sending |
| rx_last_wr_i | input | 1 | Last descriptor of a received frame is being written |
| sint_flag_o | output | 1 | Sticky system-error flag |
| irq_o | output | 1 | Interrupt request |
| stop_req_o | output | 1 | One-cycle stop request |
| tx_abort_req_o | output | 1 | Orderly transmit abort request |
| tx_desc_set_o | output | 32 | Bits to set in the transmit descriptor's second word |
| rx_desc_set_o | output | 32 | Bits to set in the last receive descriptor's second word |

## Verification
The bench builds the block with its defaults: a 32-bit descriptor word, the error bit at position 23, and an 8-bit style field. It sweeps styles 0 to 7 against both enable settings and all eight transfer kinds. Every combination of mode and kind is therefore checked against its outcome, including the styles that silently fall back to basic mode. Directed cases then cover the drain wait behind a busy transmitter, errors arriving mid-sequence, and a clear colliding with a new error.

// File: rtl/dma_perr_pkg.sv
package dma_perr_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_INIT_RD = 3'd0,
        K_DESC_RD = 3'd1,
        K_DESC_WR = 3'd2,
        K_TXBUF_RD = 3'd3,
        K_RXBUF_WR = 3'd4,
        K_OTHER5 = 3'd5,
        K_OTHER6 = 3'd6,
        K_OTHER7 = 3'd7
    } xfer_kind_e;

    typedef struct packed {
        logic go_stop;
        logic need_drain;
        logic tx_mark;
        logic rx_mark;
    } perr_action_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_DRAIN = 2'd1,
        SQ_FIRE = 2'd2
    } stop_state_e;

    function automatic logic style_is_wide(input logic [7:0] style);
        return (style == 8'd2) || (style == 8'd3);
    endfunction

    function automatic logic [31:0] bit_mask(input int unsigned pos);
        logic [31:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dma_perr_classify.sv
module dma_perr_classify
    import dma_perr_pkg::*;
#(
    parameter int STYLE_W = 8
) (
    input  logic               perr,
    input  logic [KIND_W-1:0]  kind,
    input  logic               adv_en,
    input  logic [STYLE_W-1:0] style,
    output perr_action_t       act
);
    logic adv_live;
    logic [7:0] style8;

    generate
        if (STYLE_W >= 8) begin : g_wide
            assign style8 = style[7:0];
        end else begin : g_narrow
            assign style8 = {{(8-STYLE_W){1'b0}}, style};
        end
    endgenerate

    assign adv_live = adv_en && style_is_wide(style8);

    always_comb begin
        act = '0;
        if (perr && adv_live) begin
            case (xfer_kind_e'(kind))
                K_INIT_RD: act.go_stop = 1'b1;
                K_DESC_RD, K_DESC_WR: begin
                    act.go_stop = 1'b1;
                    act.need_drain = 1'b1;
                end
                K_TXBUF_RD: act.tx_mark = 1'b1;
                K_RXBUF_WR: act.rx_mark = 1'b1;
                default: act = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_perr_flag.sv
module dma_perr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
    assign irq = flag & ie;
endmodule

// File: rtl/dma_perr_stop_seq.sv
module dma_perr_stop_seq
    import dma_perr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic need_drain,
    input  logic tx_busy,
    output logic draining,
    output logic stop_pulse
);
    stop_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            SQ_IDLE:  if (go) st_nx = (need_drain && tx_busy) ? SQ_DRAIN : SQ_FIRE;
            SQ_DRAIN: if (!tx_busy) st_nx = SQ_FIRE;
            SQ_FIRE:  st_nx = SQ_IDLE;
            default:  st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else st <= st_nx;
    end

    assign draining = (st == SQ_DRAIN);
    assign stop_pulse = (st == SQ_FIRE);
endmodule

// File: rtl/dma_perr_ctrl.sv
module dma_perr_ctrl
    import dma_perr_pkg::*;
#(
    parameter int DESC_W = 32,
    parameter int BPE_POS = 23,
    parameter int STYLE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               perr_i,
    input  logic [2:0]         perr_kind_i,
    input  logic               sint_ie_i,
    input  logic               adv_en_i,
    input  logic [STYLE_W-1:0] desc_style_i,
    input  logic               sint_clr_i,
    input  logic               tx_busy_i,
    input  logic               rx_last_wr_i,
    output logic               sint_flag_o,
    output logic               irq_o,
    output logic               stop_req_o,
    output logic               tx_abort_req_o,
    output logic [DESC_W-1:0]  tx_desc_set_o,
    output logic [DESC_W-1:0]  rx_desc_set_o
);
    localparam logic [DESC_W-1:0] BPE_MASK = DESC_W'(1) << BPE_POS;

    perr_action_t act;
    logic draining;
    logic tx_mark_q;
    logic rx_pend_q;
    logic rx_hit;

    dma_perr_classify #(.STYLE_W(STYLE_W)) u_cls (
        .perr(perr_i), .kind(perr_kind_i), .adv_en(adv_en_i),
        .style(desc_style_i), .act(act)
    );

    dma_perr_flag u_flag (
        .clk(clk), .rst(rst), .set(perr_i), .clr(sint_clr_i),
        .ie(sint_ie_i), .flag(sint_flag_o), .irq(irq_o)
    );

    dma_perr_stop_seq u_seq (
        .clk(clk), .rst(rst), .go(act.go_stop), .need_drain(act.need_drain),
        .tx_busy(tx_busy_i), .draining(draining), .stop_pulse(stop_req_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_mark_q <= 1'b0;
            rx_pend_q <= 1'b0;
        end else begin
            tx_mark_q <= act.tx_mark;
            rx_pend_q <= rx_last_wr_i ? 1'b0 : (rx_pend_q | act.rx_mark);
        end
    end

    assign rx_hit = rx_last_wr_i && (rx_pend_q || act.rx_mark);
    assign tx_abort_req_o = tx_mark_q | draining;
    assign tx_desc_set_o = tx_mark_q ? BPE_MASK : '0;
    assign rx_desc_set_o = rx_hit ? BPE_MASK : '0;
endmodule

// File: rtl/dma_perr_ctrl_chk.sv
module dma_perr_ctrl_chk #(
    parameter int DESC_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              perr_i,
    input logic              sint_ie_i,
    input logic              sint_clr_i,
    input logic              rx_last_wr_i,
    input logic              sint_flag_o,
    input logic              irq_o,
    input logic              stop_req_o,
    input logic              tx_abort_req_o,
    input logic [DESC_W-1:0] tx_desc_set_o,
    input logic [DESC_W-1:0] rx_desc_set_o
);
    a_r1_flag_sets: assert property (@(posedge clk) disable iff (rst)
        perr_i |=> sint_flag_o);
    a_r1_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (sint_flag_o && !sint_clr_i) |=> sint_flag_o);
    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (sint_ie_i && sint_flag_o));
    a_r3_clear_works: assert property (@(posedge clk) disable iff (rst)
        (sint_clr_i && !perr_i) |=> !sint_flag_o);
    a_r5_stop_single: assert property (@(posedge clk) disable iff (rst)
        stop_req_o |=> !stop_req_o);
    a_r7_mark_with_abort: assert property (@(posedge clk) disable iff (rst)
        (tx_desc_set_o != '0) |-> tx_abort_req_o);
    a_r8_rx_mark_on_last: assert property (@(posedge clk) disable iff (rst)
        (rx_desc_set_o != '0) |-> rx_last_wr_i);
endmodule

bind dma_perr_ctrl dma_perr_ctrl_chk #(.DESC_W(DESC_W)) u_chk (.*);

// File: tb/test_dma_perr_ctrl.sv
module test_dma_perr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 100000;
    localparam logic [31:0] MASK = 32'h0080_0000;

    logic clk = 1'b0;
    logic rst, perr, ie, adv, clr, busy, rxl;
    logic [2:0] kind;
    logic [7:0] style;
    logic flag, irq, stp, abrt;
    logic [31:0] txs, rxs;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dma_perr_ctrl i_dma_perr_ctrl (
        .clk(clk), .rst(rst), .perr_i(perr), .perr_kind_i(kind),
        .sint_ie_i(ie), .adv_en_i(adv), .desc_style_i(style),
        .sint_clr_i(clr), .tx_busy_i(busy), .rx_last_wr_i(rxl),
        .sint_flag_o(flag), .irq_o(irq), .stop_req_o(stp),
        .tx_abort_req_o(abrt), .tx_desc_set_o(txs), .rx_desc_set_o(rxs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs change at negedge; registered outputs are sampled 1 time unit after posedge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drv();
        @(negedge clk);
    endtask

    task automatic do_reset();
        drv();
        rst = 1; perr = 0; clr = 0; busy = 0; rxl = 0; kind = 0;
        tick(); tick();
        drv();
        rst = 0;
    endtask

    initial begin
        rst = 1; perr = 0; kind = 0; ie = 0; adv = 0; style = 0;
        clr = 0; busy = 0; rxl = 0;
        do_reset();
        chk("R1 reset flag", 32'(flag), 0);
        chk("R5 reset stop", 32'(stp), 0);
        chk("R6 reset abort", 32'(abrt), 0);

        for (int a = 0; a < 2; a++) begin
            for (int s = 0; s < 8; s++) begin
                for (int k = 0; k < 8; k++) begin
                    logic eff;
                    eff = (a == 1) && (s == 2 || s == 3);
                    adv = a[0]; style = 8'(s); ie = 0;
                    do_reset();
                    perr = 1; kind = 3'(k);
                    tick();
                    chk("R1 flag set", 32'(flag), 1);
                    chk("R4/R5/R6 stop", 32'(stp), 32'(eff && k <= 2));
                    chk("R7 tx abort", 32'(abrt), 32'(eff && k == 3));
                    chk("R7 tx mark", txs, (eff && k == 3) ? MASK : 0);
                    chk("R2 irq off", 32'(irq), 0);
                    drv(); perr = 0; ie = 1; #1;
                    chk("R2 irq on", 32'(irq), 1);
                    tick();
                    chk("R5 stop one cycle", 32'(stp), 0);
                    chk("R7 abort one cycle", 32'(abrt), 0);
                    chk("R1 sticky", 32'(flag), 1);
                    drv(); rxl = 1; #1;
                    chk("R8 rx mark", rxs, (eff && k == 4) ? MASK : 0);
                    tick();
                    drv(); rxl = 0; #1;
                    chk("R8 rx cleared", rxs, 0);
                    rxl = 1; #1;
                    chk("R8 pending cleared", rxs, 0);
                    drv(); rxl = 0;
                end
            end
        end

        // R3 clear, and clear colliding with an error
        adv = 1; style = 2; ie = 1;
        do_reset();
        kind = 5; perr = 1; tick();
        drv(); perr = 0; clr = 1; tick();
        chk("R3 cleared", 32'(flag), 0);
        chk("R2 irq follows clear", 32'(irq), 0);
        drv(); perr = 1; clr = 1; tick();
        chk("R3 error wins", 32'(flag), 1);
        chk("R9 kind5 no stop", 32'(stp), 0);
        drv(); perr = 0; clr = 0;

        // R6 drain behind busy transmitter, R9 errors during drain
        do_reset();
        busy = 1; kind = 1; perr = 1; tick();
        chk("R6 abort held", 32'(abrt), 1);
        chk("R6 no early stop", 32'(stp), 0);
        drv(); kind = 0; perr = 1; tick();
        chk("R9 init during drain no stop", 32'(stp), 0);
        drv(); perr = 0; tick(); tick();
        chk("R6 still draining", 32'(abrt), 1);
        drv(); busy = 0; tick();
        chk("R6 stop after drain", 32'(stp), 1);
        chk("R6 abort drops", 32'(abrt), 0);
        tick();
        chk("R9 no second stop", 32'(stp), 0);

        // R6 descriptor write with idle transmitter
        do_reset();
        kind = 2; perr = 1; tick();
        chk("R6 idle stop", 32'(stp), 1);
        chk("R6 idle no abort", 32'(abrt), 0);
        drv(); perr = 0;

        // R8 error and last write in same cycle
        do_reset();
        kind = 4; perr = 1; rxl = 1; #1;
        chk("R8 same cycle mark", rxs, MASK);
        tick();
        drv(); perr = 0; #1;
        chk("R8 no leftover", rxs, 0);
        drv(); rxl = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= WATCHDOG);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule